// File: doc/BRIEF.md
# Comparator Trigger Status Register

This block is a 32-bit status register that belongs to one pulse-width generator. It watches eight comparator trigger lines and lets software see them in one of two ways, chosen at run time by a mode input. In live mode a read returns the present level of every trigger, and the register cannot be written. In latched mode each bit is sticky: it records that its trigger went active and keeps that record until software writes a 1 to that bit position.

The trigger lines are asynchronous to the register clock, so each one passes through a two-stage synchronizer before it is used. A small synchronous register bus gives access. It has an address, a write strobe with write data, and a read strobe with registered read data. A write changes the register only when the fault-source extension enable input is high and the address matches. Every trigger line is reported whether or not the generator uses it, so no per-source mask exists.

Top module: `trig_stat_reg`

## Requirements
- R1: After reset every stored bit is 0, `rd_data` is 0, and a latched-mode read returns 0 until a trigger goes active.
- R2: Bit i of the register (i = 0..7) reports trigger line `trig_i[i]`. Bits 31 to 8 always read 0, even after a write of all ones.
- R3: With `latch_en` = 0, a read returns the synchronized trigger levels. After a trigger input changes, a read whose strobe is taken at the second rising edge still returns the old level. A read whose strobe is taken at the third rising edge returns the new level.
- R4: With `latch_en` = 1, a bit becomes 1 once its synchronized trigger is high, even for a single-clock pulse. It stays 1 after the trigger falls.
- R5: In latched mode, a write with data bit i = 1 clears stored bit i. A write with data bit i = 0 leaves it unchanged.
- R6: A write has effect only when `wr_en` = 1, `ext_en` = 1 and `addr` equals `STAT_ADDR` (default 0x08). Any other write leaves the stored bits unchanged.
- R7: If a synchronized trigger is high in the same cycle as a write-1 clear of its bit, the bit stays 1.
- R8: While `latch_en` = 0, the stored sticky bits are held at 0. When latched mode is entered again, every bit starts from 0.
- R9: Read data is registered. It appears one clock after `rd_en` is sampled and holds until the next read strobe. A read has no side effect. A read from any address other than `STAT_ADDR` returns 0.
- R10: In live mode, writes have no effect on what later reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | N_TRIG (8) | Asynchronous comparator trigger lines, active high |
| latch_en | input | 1 | 1 = sticky write-1-to-clear mode, 0 = live read-only mode |
| ext_en | input | 1 | Fault-source extension enable; writes are accepted only when 1 |
| addr | input | ADDR_W (8) | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data; a 1 in bits 7..0 clears the matching sticky bit |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Registered read data |

## Verification
A trigger change reaches the synchronized level after two rising edges. A live read therefore reflects it when its strobe is taken at the third edge. A sticky bit is set at the third edge, and a read placed after that returns it. A write changes the sticky state at the edge on which the write strobe is sampled. Read data appears at the edge that samples the read strobe. The bench drives every strobe on a falling edge and samples `rd_data` on the next falling edge. It waits at least four clocks after each trigger change before a read whose result depends on that change. The latency test alone sets its read strobes on purpose at the second and third edges, and expects the old and the new level in turn.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic {
    MODE_LIVE  = 1'b0,
    MODE_LATCH = 1'b1
  } tsr_mode_e;

  localparam int unsigned TSR_SYNC_STAGES = 2;

endpackage

// File: rtl/tsr_rst_sync.sv
module tsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  import tsr_pkg::*;

  logic [W-1:0] chain_q [TSR_SYNC_STAGES];

  for (genvar s = 0; s < TSR_SYNC_STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_rest
      assign stage_d = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[s] <= '0;
      end else begin
        chain_q[s] <= stage_d;
      end
    end
  end

  assign q_o = chain_q[TSR_SYNC_STAGES-1];

endmodule

// File: rtl/tsr_sticky.sv
module tsr_sticky #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch_en,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] bit_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_d;
    logic bit_en;

    // set has priority over a clear in the same cycle
    always_comb begin
      if (latch_en) begin
        bit_d = set_i[i] | (bit_q[i] & ~clr_i[i]);
      end else begin
        bit_d = 1'b0;
      end
      bit_en = (bit_d != bit_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q[i] <= 1'b0;
      end else if (bit_en) begin
        bit_q[i] <= bit_d;
      end
    end
  end

  assign q_o = bit_q;

endmodule

// File: rtl/tsr_rdport.sv
module tsr_rdport #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_TRIG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 hit,
  input  tsr_pkg::tsr_mode_e   mode,
  input  logic [N_TRIG-1:0]    live_i,
  input  logic [N_TRIG-1:0]    sticky_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  import tsr_pkg::*;

  logic [N_TRIG-1:0] sel_val;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic              rd_load;

  always_comb begin
    sel_val = (mode == MODE_LATCH) ? sticky_i : live_i;
    rd_d    = '0;
    if (hit) begin
      rd_d[N_TRIG-1:0] = sel_val;
    end
    rd_load = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_load) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/trig_stat_reg.sv
module trig_stat_reg #(
  parameter int unsigned          N_TRIG    = 8,
  parameter int unsigned          DATA_W    = 32,
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    STAT_ADDR = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              latch_en,
  input  logic              ext_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);

  import tsr_pkg::*;

  localparam int unsigned HI_W = DATA_W - N_TRIG;

  logic              rst_q_n;
  logic [N_TRIG-1:0] sync_trig;
  logic [N_TRIG-1:0] sticky_q;
  logic [N_TRIG-1:0] clr_vec;
  logic              addr_hit;
  logic              wr_accept;
  tsr_mode_e         mode;

  tsr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tsr_sync #(.W(N_TRIG)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   (trig_i),
    .q_o   (sync_trig)
  );

  always_comb begin
    addr_hit  = (addr == STAT_ADDR);
    wr_accept = wr_en & ext_en & addr_hit;
    clr_vec   = wr_accept ? wr_data[N_TRIG-1:0] : '0;
    mode      = latch_en ? MODE_LATCH : MODE_LIVE;
  end

  if (HI_W > 0) begin : g_hi
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DATA_W-1:N_TRIG];
  end

  tsr_sticky #(.W(N_TRIG)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .latch_en (latch_en),
    .set_i    (sync_trig),
    .clr_i    (clr_vec),
    .q_o      (sticky_q)
  );

  tsr_rdport #(.DATA_W(DATA_W), .N_TRIG(N_TRIG)) u_rd (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rd_en     (rd_en),
    .hit       (addr_hit),
    .mode      (mode),
    .live_i    (sync_trig),
    .sticky_i  (sticky_q),
    .rd_data_o (rd_data)
  );

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int unsigned       N_TRIG    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_en,
  input logic              ext_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [N_TRIG-1:0] trig_s,
  input logic [N_TRIG-1:0] sticky
);

  logic hit;
  logic wr_ok;
  assign hit   = (addr == STAT_ADDR);
  assign wr_ok = wr_en & ext_en & hit;

  // R2: reserved bits never set
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:N_TRIG] == '0);

  // R9: read data holds without a strobe
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R8: sticky state forced to zero while latch mode is off
  assert_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> sticky == '0);

  // R4 / R7: a high synchronized trigger always leaves its bit set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> ((sticky & $past(trig_s)) == $past(trig_s)));

  // R6: without an accepted write no stored bit drops
  assert_no_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !wr_ok) |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R3: live read returns synchronized levels
  assert_live_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && !latch_en) |=> rd_data[N_TRIG-1:0] == $past(trig_s));

endmodule

bind trig_stat_reg tsr_checker #(
  .N_TRIG    (N_TRIG),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .latch_en (latch_en),
  .ext_en   (ext_en),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .trig_s   (sync_trig),
  .sticky   (sticky_q)
);

// File: tb/sim_trig_stat_reg.sv
`timescale 1ns/1ps
module sim_trig_stat_reg;

  localparam logic [7:0] A_STAT = 8'h08;

  logic        clk;
  logic        rst_n;
  logic [7:0]  trig_i;
  logic        latch_en;
  logic        ext_en;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;

  int n_chk;
  int n_bad;
  bit done;

  trig_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .latch_en(latch_en),
    .ext_en(ext_en), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; addr = A_STAT;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string what);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; addr = A_STAT;
    check(rd_data, exp, what);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    trig_i = v;
    @(negedge clk);
    trig_i = '0;
    idle(4);
  endtask

  task automatic t_reset;
    check(rd_data, 32'h0, "R1 rd_data after reset");
    latch_en = 1'b1; ext_en = 1'b1;
    idle(2);
    bus_read(A_STAT, 32'h0, "R1 latched read after reset");
    latch_en = 1'b0;
    idle(2);
  endtask

  task automatic t_layout;
    trig_i = 8'hFF; idle(4);
    bus_read(A_STAT, 32'h0000_00FF, "R2 all triggers, upper bits zero");
    trig_i = 8'h04; idle(4);
    bus_read(A_STAT, 32'h0000_0004, "R2 trigger 2 at bit 2");
    trig_i = 8'h00; idle(4);
  endtask

  task automatic t_live_latency;
    // trigger changes on this falling edge; edges e1,e2 fill the synchronizer
    @(negedge clk);
    trig_i = 8'hA5;
    @(negedge clk);                  // e1 passed
    addr = A_STAT; rd_en = 1'b1;
    @(negedge clk);                  // strobe sampled at e2
    check(rd_data, 32'h0, "R3 read at second edge returns old level");
    @(negedge clk);                  // strobe sampled at e3
    rd_en = 1'b0;
    check(rd_data, 32'h0000_00A5, "R3 read at third edge returns new level");
    trig_i = 8'h00; idle(4);
    bus_read(A_STAT, 32'h0, "R3 live read follows trigger fall");
  endtask

  task automatic t_live_write;
    ext_en = 1'b1; latch_en = 1'b0;
    trig_i = 8'h3C; idle(4);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, 32'h0000_003C, "R10 live write has no effect");
    trig_i = 8'h00; idle(4);
  endtask

  task automatic t_latch_set;
    latch_en = 1'b1; ext_en = 1'b1; idle(2);
    pulse(8'h81);
    bus_read(A_STAT, 32'h0000_0081, "R4 one-clock pulses captured");
    bus_read(A_STAT, 32'h0000_0081, "R9 read has no side effect");
  endtask

  task automatic t_clear;
    bus_write(A_STAT, 32'h0000_0001);
    bus_read(A_STAT, 32'h0000_0080, "R5 write 1 clears bit 0");
    bus_write(A_STAT, 32'h0000_0000);
    bus_read(A_STAT, 32'h0000_0080, "R5 write 0 leaves bits");
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, 32'h0, "R5 write all ones clears, R2 upper stays zero");
  endtask

  task automatic t_ext_gate;
    pulse(8'h42);
    bus_read(A_STAT, 32'h0000_0042, "R6 bits set before gated writes");
    ext_en = 1'b0;
    bus_write(A_STAT, 32'h0000_00FF);
    bus_read(A_STAT, 32'h0000_0042, "R6 write ignored with ext_en low");
    ext_en = 1'b1;
    bus_write(8'h0C, 32'h0000_00FF);
    bus_read(A_STAT, 32'h0000_0042, "R6 write to other address ignored");
    bus_write(A_STAT, 32'h0000_00FF);
    bus_read(A_STAT, 32'h0, "R6 accepted write clears");
  endtask

  task automatic t_set_wins;
    trig_i = 8'h10; idle(4);
    bus_write(A_STAT, 32'h0000_0010);
    bus_read(A_STAT, 32'h0000_0010, "R7 set wins over clear");
    trig_i = 8'h00; idle(4);
    bus_write(A_STAT, 32'h0000_0010);
    bus_read(A_STAT, 32'h0, "R7 clear works once trigger low");
  endtask

  task automatic t_mode_off;
    pulse(8'h0F);
    bus_read(A_STAT, 32'h0000_000F, "R8 sticky bits before mode off");
    latch_en = 1'b0; idle(3);
    bus_read(A_STAT, 32'h0, "R8 live read with triggers low");
    latch_en = 1'b1; idle(2);
    bus_read(A_STAT, 32'h0, "R8 sticky bits start from zero");
  endtask

  task automatic t_read_hold;
    pulse(8'h21);
    bus_read(A_STAT, 32'h0000_0021, "R9 read value");
    pulse(8'h02);
    check(rd_data, 32'h0000_0021, "R9 rd_data holds without strobe");
    bus_read(8'h10, 32'h0, "R9 other address reads zero");
    bus_read(A_STAT, 32'h0000_0023, "R9 next read updates");
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; trig_i = '0; latch_en = 1'b0; ext_en = 1'b0;
    addr = A_STAT; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    t_reset;
    t_layout;
    t_live_latency;
    t_live_write;
    t_latch_set;
    t_clear;
    t_ext_gate;
    t_set_wins;
    t_mode_off;
    t_read_hold;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
    end
  end

endmodule